// File: doc/BRIEF.md
# Instruction Decode and Control Unit

This block is the combinational main control of a small 16-bit load/store processor. It takes one 16-bit instruction word and produces everything the datapath needs for that instruction in the same cycle. That covers the register-file read and write indices, the register write enable and the ALU operation and operand source. It also covers the data-memory read and write strobes, the writeback source and a 16-bit immediate. The immediate is cut from whichever field the instruction format uses and then extended to 16 bits.

Every instruction has its opcode in bits 15:12. Any format that reads a first source register takes its index from bits 11:9. The destination index is in a different place in each format, and the immediate is 6, 9 or 12 bits wide depending on the format. The decoder resolves both of these so the datapath never needs to know the format. Branch, jump and system instructions only get safe control values here. The one exception is the linking jump, which requests a write of the return address into register 2 through a separate link select. The ALU, the register storage, the memories and next-PC logic sit outside this block.

Top module: `instr_decode`

## Requirements
- R1: Opcode 0000 selects register-register form. rs1 comes from bits 11:9, rs2 from bits 8:6 and rd from bits 5:3. The ALU select equals funct3 (bits 2:0) with a leading 0, giving ADD=0, SUB=1, SLT=2, AND=3, OR=4, XOR=5, LSL=6 and LSR=7. The B operand comes from the register and the immediate is 0.
- R2: The register-immediate opcodes take rs1 from 11:9 and rd from 8:6, and they set the B operand to the immediate. The ALU select follows the opcode: 0001 gives 0 (add), 0010 gives 1 (sub), 0011 gives 6 (shift left), 0100 gives 5 (xor), 0101 gives 3 (and) and 0110 gives 4 (or).
- R3: The 6-bit immediate of 0001 and 0010 is sign-extended. The 6-bit immediate of 0011, 0100, 0101 and 0110 is zero-extended.
- R4: Opcode 0111 (load) takes rs1 from 11:9 and rd from 8:6. It asserts register write and memory read, selects memory as the writeback source and uses the immediate as B with ALU add. Its immediate is bits 5:0, sign-extended.
- R5: Opcode 1000 (load immediate) takes rd from bits 11:9 and forces rs1 to 0. It uses the immediate as B with ALU add and asserts register write. Its immediate is bits 8:0, sign-extended.
- R6: Opcode 1001 (store) takes rs1 from 11:9 and rs2 from 8:6. It asserts memory write and no register write, and it uses the immediate as B with ALU add. Its immediate is bits 5:0, sign-extended.
- R7: Opcodes 1010 and 1011 (branch on zero / non-zero) take rs1 from 11:9 with rs2 forced to 0. They select ALU subtract with a register B operand and assert no write. Their immediate is bits 8:0, sign-extended.
- R8: Opcode 1100 (jump) asserts no write. Opcode 1101 (linking jump) sets rd=2, asserts register write and the link select, and asserts no memory access. Both use bits 11:0, sign-extended, as the immediate.
- R9: A register write whose destination index is 0 is suppressed.
- R10: Opcodes 1110 (any funct3) and 1111 act as no-operations. All enables and selects are 0, all indices are 0 and the immediate is 0.
- R11: Memory read and memory write are never asserted together, and the memory writeback select is asserted only together with memory read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 16 | Instruction word |
| rs1_o | output | 3 | First source register index |
| rs2_o | output | 3 | Second source register index |
| rd_o | output | 3 | Destination register index |
| reg_we_o | output | 1 | Register-file write enable |
| alu_b_imm_o | output | 1 | ALU B operand: 1 = immediate, 0 = register |
| alu_sel_o | output | 4 | ALU operation code |
| mem_rd_o | output | 1 | Data-memory read enable |
| mem_we_o | output | 1 | Data-memory write enable |
| wb_mem_o | output | 1 | Writeback source: 1 = memory, 0 = ALU |
| wb_link_o | output | 1 | Writeback source override: return address |
| imm_o | output | 16 | Extended immediate |

## Verification
The assertions check the control invariants on every evaluation. These are the exclusive memory strobes, no write to register 0, a silent system/reserved space and store never writing a register. They also check that the link select appears only with a write to register 2. The exact field placement per format, the ALU code for each opcode and the choice between sign and zero extension are only shown by the bench. The bench applies all 65,536 instruction words and compares each one against an independent behavioural decode.

// File: rtl/instr_decode.sv
module instr_decode #(
  parameter int XLEN = 16,
  parameter int RIDX = 3,
  parameter int LINK_REG = 2
) (
  input  logic [15:0]     instr_i,
  output logic [RIDX-1:0] rs1_o,
  output logic [RIDX-1:0] rs2_o,
  output logic [RIDX-1:0] rd_o,
  output logic            reg_we_o,
  output logic            alu_b_imm_o,
  output logic [3:0]      alu_sel_o,
  output logic            mem_rd_o,
  output logic            mem_we_o,
  output logic            wb_mem_o,
  output logic            wb_link_o,
  output logic [XLEN-1:0] imm_o
);

  localparam logic [3:0] ALU_ADD = 4'd0;
  localparam logic [3:0] ALU_SUB = 4'd1;
  localparam logic [3:0] ALU_AND = 4'd3;
  localparam logic [3:0] ALU_OR  = 4'd4;
  localparam logic [3:0] ALU_XOR = 4'd5;
  localparam logic [3:0] ALU_LSL = 4'd6;

  localparam logic [1:0] CLS_FUNCT = 2'b00;
  localparam logic [1:0] CLS_OPC   = 2'b01;
  localparam logic [1:0] CLS_ADD   = 2'b10;
  localparam logic [1:0] CLS_SUB   = 2'b11;

  typedef enum logic [2:0] {IMM_NONE, IMM_S6, IMM_Z6, IMM_S9, IMM_S12} imm_kind_e;

  logic [3:0]      opc;
  logic [2:0]      fn3;
  logic [RIDX-1:0] f_hi, f_mid, f_lo;
  logic [1:0]      alu_cls;
  imm_kind_e       ikind;
  logic            we_raw;
  logic [3:0]      opc_alu;

  assign opc   = instr_i[15:12];
  assign fn3   = instr_i[2:0];
  assign f_hi  = instr_i[11:9];
  assign f_mid = instr_i[8:6];
  assign f_lo  = instr_i[5:3];

  always_comb begin
    rs1_o       = '0;
    rs2_o       = '0;
    rd_o        = '0;
    we_raw      = 1'b0;
    alu_b_imm_o = 1'b0;
    alu_cls     = CLS_ADD;
    mem_rd_o    = 1'b0;
    mem_we_o    = 1'b0;
    wb_mem_o    = 1'b0;
    wb_link_o   = 1'b0;
    ikind       = IMM_NONE;
    unique case (opc)
      4'b0000: begin
        rs1_o   = f_hi;
        rs2_o   = f_mid;
        rd_o    = f_lo;
        we_raw  = 1'b1;
        alu_cls = CLS_FUNCT;
      end
      4'b0001, 4'b0010: begin
        rs1_o       = f_hi;
        rd_o        = f_mid;
        we_raw      = 1'b1;
        alu_b_imm_o = 1'b1;
        alu_cls     = CLS_OPC;
        ikind       = IMM_S6;
      end
      4'b0011, 4'b0100, 4'b0101, 4'b0110: begin
        rs1_o       = f_hi;
        rd_o        = f_mid;
        we_raw      = 1'b1;
        alu_b_imm_o = 1'b1;
        alu_cls     = CLS_OPC;
        ikind       = IMM_Z6;
      end
      4'b0111: begin
        rs1_o       = f_hi;
        rd_o        = f_mid;
        we_raw      = 1'b1;
        alu_b_imm_o = 1'b1;
        mem_rd_o    = 1'b1;
        wb_mem_o    = 1'b1;
        ikind       = IMM_S6;
      end
      4'b1000: begin
        rd_o        = f_hi;
        we_raw      = 1'b1;
        alu_b_imm_o = 1'b1;
        ikind       = IMM_S9;
      end
      4'b1001: begin
        rs1_o       = f_hi;
        rs2_o       = f_mid;
        alu_b_imm_o = 1'b1;
        mem_we_o    = 1'b1;
        ikind       = IMM_S6;
      end
      4'b1010, 4'b1011: begin
        rs1_o   = f_hi;
        alu_cls = CLS_SUB;
        ikind   = IMM_S9;
      end
      4'b1100: begin
        ikind = IMM_S12;
      end
      4'b1101: begin
        rd_o      = RIDX'(LINK_REG);
        we_raw    = 1'b1;
        wb_link_o = 1'b1;
        ikind     = IMM_S12;
      end
      default: begin
      end
    endcase
  end

  always_comb begin
    unique case (opc)
      4'b0010: opc_alu = ALU_SUB;
      4'b0011: opc_alu = ALU_LSL;
      4'b0100: opc_alu = ALU_XOR;
      4'b0101: opc_alu = ALU_AND;
      4'b0110: opc_alu = ALU_OR;
      default: opc_alu = ALU_ADD;
    endcase
  end

  always_comb begin
    unique case (alu_cls)
      CLS_FUNCT: alu_sel_o = {1'b0, fn3};
      CLS_OPC:   alu_sel_o = opc_alu;
      CLS_SUB:   alu_sel_o = ALU_SUB;
      default:   alu_sel_o = ALU_ADD;
    endcase
  end

  assign reg_we_o = we_raw && (rd_o != '0);

  always_comb begin
    unique case (ikind)
      IMM_S6:  imm_o = {{(XLEN-6){instr_i[5]}}, instr_i[5:0]};
      IMM_Z6:  imm_o = {{(XLEN-6){1'b0}}, instr_i[5:0]};
      IMM_S9:  imm_o = {{(XLEN-9){instr_i[8]}}, instr_i[8:0]};
      IMM_S12: imm_o = {{(XLEN-12){instr_i[11]}}, instr_i[11:0]};
      default: imm_o = '0;
    endcase
  end

endmodule

// File: rtl/instr_decode_props.sv
module instr_decode_props (
  input logic [15:0] instr_i,
  input logic [2:0]  rs1_o,
  input logic [2:0]  rs2_o,
  input logic [2:0]  rd_o,
  input logic        reg_we_o,
  input logic        alu_b_imm_o,
  input logic [3:0]  alu_sel_o,
  input logic        mem_rd_o,
  input logic        mem_we_o,
  input logic        wb_mem_o,
  input logic        wb_link_o,
  input logic [15:0] imm_o
);
  always_comb begin
    a_r11_mem_exclusive: assert (!(mem_rd_o && mem_we_o));
    a_r11_wb_needs_read: assert (!wb_mem_o || mem_rd_o);
    a_r9_no_r0_write:    assert (!reg_we_o || rd_o != 3'd0);
    a_r10_sys_quiet:     assert (instr_i[15:13] != 3'b111 ||
                                 !(reg_we_o || mem_rd_o || mem_we_o || wb_mem_o ||
                                   wb_link_o || alu_b_imm_o) && imm_o == 16'd0);
    a_r6_store_no_write: assert (!mem_we_o || !reg_we_o);
    a_r8_link_to_r2:     assert (!wb_link_o || (reg_we_o && rd_o == 3'd2 && !mem_rd_o));
  end
endmodule

bind instr_decode instr_decode_props u_props (
  .instr_i(instr_i), .rs1_o(rs1_o), .rs2_o(rs2_o), .rd_o(rd_o),
  .reg_we_o(reg_we_o), .alu_b_imm_o(alu_b_imm_o), .alu_sel_o(alu_sel_o),
  .mem_rd_o(mem_rd_o), .mem_we_o(mem_we_o), .wb_mem_o(wb_mem_o),
  .wb_link_o(wb_link_o), .imm_o(imm_o)
);

// File: tb/instr_decode_test.sv
module instr_decode_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] instr;
  logic [2:0]  rs1, rs2, rd;
  logic        we, bimm, mrd, mwe, wbm, lnk;
  logic [3:0]  sel;
  logic [15:0] imm;
  int total = 0;
  int bad = 0;
  bit done = 0;

  instr_decode uut (
    .instr_i(instr), .rs1_o(rs1), .rs2_o(rs2), .rd_o(rd), .reg_we_o(we),
    .alu_b_imm_o(bimm), .alu_sel_o(sel), .mem_rd_o(mrd), .mem_we_o(mwe),
    .wb_mem_o(wbm), .wb_link_o(lnk), .imm_o(imm)
  );

  function automatic int sx(input int v, input int bits);
    int half;
    half = 1 << (bits - 1);
    return (v >= half) ? v - (half * 2) : v;
  endfunction

  function automatic logic [34:0] model(input logic [15:0] w);
    int op, a, b, c, e, bi, s, r, m, wm, l, iv;
    int imap[6];
    imap = '{0, 1, 6, 5, 3, 4};
    op = int'(w[15:12]);
    a = 0; b = 0; c = 0; e = 0; bi = 0; s = 0; r = 0; m = 0; wm = 0; l = 0; iv = 0;
    if (op == 0) begin
      a = int'(w[11:9]); b = int'(w[8:6]); c = int'(w[5:3]); e = 1; s = int'(w[2:0]);
    end else if (op >= 1 && op <= 6) begin
      a = int'(w[11:9]); c = int'(w[8:6]); e = 1; bi = 1; s = imap[op-1];
      iv = (op <= 2) ? sx(int'(w[5:0]), 6) : int'(w[5:0]);
    end else if (op == 7) begin
      a = int'(w[11:9]); c = int'(w[8:6]); e = 1; bi = 1; r = 1; wm = 1;
      iv = sx(int'(w[5:0]), 6);
    end else if (op == 8) begin
      c = int'(w[11:9]); e = 1; bi = 1; iv = sx(int'(w[8:0]), 9);
    end else if (op == 9) begin
      a = int'(w[11:9]); b = int'(w[8:6]); bi = 1; m = 1; iv = sx(int'(w[5:0]), 6);
    end else if (op == 10 || op == 11) begin
      a = int'(w[11:9]); s = 1; iv = sx(int'(w[8:0]), 9);
    end else if (op == 12) begin
      iv = sx(int'(w[11:0]), 12);
    end else if (op == 13) begin
      c = 2; e = 1; l = 1; iv = sx(int'(w[11:0]), 12);
    end
    if (c == 0) e = 0;
    return {a[2:0], b[2:0], c[2:0], e[0], bi[0], s[3:0], r[0], m[0], wm[0], l[0], iv[15:0]};
  endfunction

  function automatic string tag(input logic [15:0] w);
    case (w[15:12])
      4'd0: return (w[5:3] == 3'd0) ? "R9" : "R1";
      4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6: return "R2/R3";
      4'd7: return "R4";
      4'd8: return (w[11:9] == 3'd0) ? "R9" : "R5";
      4'd9: return "R6";
      4'd10, 4'd11: return "R7";
      4'd12, 4'd13: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic [15:0] w);
    logic [34:0] got, exp;
    @(posedge clk);
    #1 instr = w;
    @(negedge clk);
    got = {rs1, rs2, rd, we, bimm, sel, mrd, mwe, wbm, lnk, imm};
    exp = model(w);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s instr=%h actual=%h expected=%h", tag(w), w, got, exp);
    end
    total++;
    if ((mrd && mwe) || (wbm && !mrd)) begin
      bad++;
      $display("FAIL R11 instr=%h actual=rd%0b/we%0b/wb%0b expected=exclusive", w, mrd, mwe, wbm);
    end
  endtask

  initial begin
    instr = 16'hE000;
    @(negedge clk);
    total++;
    if ({we, mrd, mwe, wbm, lnk, imm} !== 21'd0) begin
      bad++;
      $display("FAIL R10 idle actual=%h expected=0", {we, mrd, mwe, wbm, lnk, imm});
    end
    apply(16'h0958);
    apply(16'h0958 | 16'h0007);
    apply(16'h0900);
    apply(16'h1EBF);
    apply(16'h5EBF);
    apply(16'h7EBF);
    apply(16'h8FFF);
    apply(16'h81FF);
    apply(16'h9FC1);
    apply(16'hA100);
    apply(16'hD800);
    apply(16'hE00C);
    apply(16'hFFFF);
    for (int i = 0; i < 65536; i++) apply(16'(i));
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule